// File: doc/BRIEF.md
# Thread Context CAM Matcher

This block decides whether a single hardware thread's interrupt context is the destination of a notification. A notification target is described by a format bit, a block number, an index, a wildcard flag and a logical-server number. The block compares that target against the second context word of each of the thread's four privilege rings: user, OS, pool and physical. When one ring accepts the target, the block reports which ring it was.

The physical ring does not keep its own CAM value. Its line is built from the chip block number, the processor id and a thread-id width selection. The OS and pool rings carry their CAM value in the context word. Format-1 targets describe a user-level event branch. They take a separate path that needs a valid OS context with an equal CAM value, and also a valid user context whose logical-server field equals the supplied number.

A request is issued with a one-cycle `start` strobe. The answer is registered on that same clock edge and is announced by a one-cycle `done` pulse. The `match` and `ring` outputs then hold their values until the next strobe.

Top module: `ctx_cam_match`

## Requirements
- R1: While reset is held, and after it is released, `done`, `match` and `ring` are 0 until the first `start`.
- R2: `done` is 1 in exactly the cycle after a cycle in which `start` is 1, and 0 in every other cycle.
- R3: `match` and `ring` change only on the edge that samples `start`=1. Otherwise they hold their value.
- R4: Every context word arrives byte-reversed. Port bits [7:0] carry the word's most significant byte, and the rest follow in the same way. After this reversal, bit 31 is the ring's valid bit, and bits [CAM_W-1:0] hold the CAM value (OS and pool rings) or the logical-server field in bits [LS_W-1:0] (user ring).
- R5: A format-0 target with the wildcard flag set always yields `match`=0.
- R6: The physical ring's line is {chip_blk, hw_idx}. With tw = 7 when `tid8_mode`=0 and tw = 8 when it is 1, hw_idx = 2^tw + (pir mod 2^tw). A valid physical ring matches when this line equals the target CAM value {tgt_blk, tgt_idx}.
- R7: For a format-0 target without the wildcard flag, the rings are tried in the order physical, pool, OS. The first ring that is valid and whose CAM value equals the target wins.
- R8: A ring whose valid bit is clear never matches, even when its CAM value equals the target.
- R9: A format-1 target matches only when all four of these hold: the OS ring is valid, the OS CAM equals the target, the user ring is valid, and the user logical-server field equals `tgt_ls`.
- R10: The ring codes are user = 0, OS = 1, pool = 2, physical = 3. Format 1 can report only the user code, and format 0 never reports it. With `match`=0, `ring` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe; all target and context inputs are sampled with it |
| tgt_fmt | input | 1 | Target format: 0 thread target, 1 user event branch |
| tgt_blk | input | BLK_W | Target block number |
| tgt_idx | input | IDX_W | Target index |
| tgt_ignore | input | 1 | Wildcard (logical server) flag |
| tgt_ls | input | LS_W | Logical-server number for format 1 |
| ctx_user_w | input | 32 | User ring context word, byte-reversed |
| ctx_os_w | input | 32 | OS ring context word, byte-reversed |
| ctx_pool_w | input | 32 | Pool ring context word, byte-reversed |
| ctx_phys_w | input | 32 | Physical ring context word, byte-reversed (valid bit only used) |
| chip_blk | input | BLK_W | This chip's block number |
| pir | input | PIR_W | Processor id of the thread |
| tid8_mode | input | 1 | Thread-id width select: 0 seven bits, 1 eight bits |
| done | output | 1 | One-cycle result strobe |
| match | output | 1 | A ring accepted the target |
| ring | output | 2 | Code of the accepting ring |

## Verification
Several rings can accept the same target in one cycle. For example, the physical line, the pool CAM and the OS CAM can all equal the target. In that case the priority logic alone decides the answer. The bench provokes this with directed cases and by biasing random stimulus, so that two or three rings often carry the target value at once. It judges each result against a model that walks the rings in priority order. The format-1 path is also driven with an OS ring that would win for format 0, to show that the user path and the OS compare are combined and not competing.

// File: rtl/ctx_cam_pkg.sv
package ctx_cam_pkg;

  localparam int CTX_WORD_W = 32;
  localparam int VALID_POS  = 31;

  typedef enum logic [1:0] {
    RING_USER = 2'd0,
    RING_OS   = 2'd1,
    RING_POOL = 2'd2,
    RING_PHYS = 2'd3
  } ring_e;

  // Word arrives most-significant byte first in the low byte lane.
  function automatic logic [CTX_WORD_W-1:0] wire_to_host(input logic [CTX_WORD_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic int unsigned tid_width(input logic tid8);
    return tid8 ? 8 : 7;
  endfunction

endpackage

// File: rtl/ctx_word_decode.sv
module ctx_word_decode
  import ctx_cam_pkg::*;
#(
  parameter int CAM_W = 24,
  parameter int LS_W  = 24
) (
  input  logic [CTX_WORD_W-1:0] raw_w,
  output logic                  vld,
  output logic [CAM_W-1:0]      cam,
  output logic [LS_W-1:0]       ls
);
  logic [CTX_WORD_W-1:0] host_w;

  always_comb begin
    host_w = wire_to_host(raw_w);
    vld    = host_w[VALID_POS];
    cam    = host_w[CAM_W-1:0];
    ls     = host_w[LS_W-1:0];
  end
endmodule

// File: rtl/ctx_hw_line.sv
module ctx_hw_line #(
  parameter int BLK_W = 4,
  parameter int IDX_W = 20,
  parameter int PIR_W = 8,
  localparam int CAM_W = BLK_W + IDX_W
) (
  input  logic [BLK_W-1:0] chip_blk,
  input  logic [PIR_W-1:0] pir,
  input  logic             tid8_mode,
  output logic [CAM_W-1:0] line
);
  logic [IDX_W-1:0] hw_idx;
  int unsigned      tw;

  always_comb begin
    tw = ctx_cam_pkg::tid_width(tid8_mode);
    for (int i = 0; i < IDX_W; i++) begin
      if (i < PIR_W && i < int'(tw))
        hw_idx[i] = pir[i];
      else
        hw_idx[i] = (i == int'(tw));
    end
    line = {chip_blk, hw_idx};
  end
endmodule

// File: rtl/ctx_ring_select.sv
module ctx_ring_select
  import ctx_cam_pkg::*;
(
  input  logic  fmt,
  input  logic  ignore_lo,
  input  logic  hit_phys,
  input  logic  hit_pool,
  input  logic  hit_os,
  input  logic  hit_user,
  output logic  sel_match,
  output ring_e sel_ring
);
  always_comb begin
    sel_match = 1'b0;
    sel_ring  = RING_USER;
    if (fmt) begin
      if (hit_user) begin
        sel_match = 1'b1;
        sel_ring  = RING_USER;
      end
    end else if (!ignore_lo) begin
      if (hit_phys) begin
        sel_match = 1'b1;
        sel_ring  = RING_PHYS;
      end else if (hit_pool) begin
        sel_match = 1'b1;
        sel_ring  = RING_POOL;
      end else if (hit_os) begin
        sel_match = 1'b1;
        sel_ring  = RING_OS;
      end
    end
  end
endmodule

// File: rtl/ctx_cam_match.sv
module ctx_cam_match
  import ctx_cam_pkg::*;
#(
  parameter int BLK_W = 4,
  parameter int IDX_W = 20,
  parameter int PIR_W = 8,
  parameter int LS_W  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tgt_fmt,
  input  logic [BLK_W-1:0] tgt_blk,
  input  logic [IDX_W-1:0] tgt_idx,
  input  logic             tgt_ignore,
  input  logic [LS_W-1:0]  tgt_ls,
  input  logic [31:0]      ctx_user_w,
  input  logic [31:0]      ctx_os_w,
  input  logic [31:0]      ctx_pool_w,
  input  logic [31:0]      ctx_phys_w,
  input  logic [BLK_W-1:0] chip_blk,
  input  logic [PIR_W-1:0] pir,
  input  logic             tid8_mode,
  output logic             done,
  output logic             match,
  output logic [1:0]       ring
);
  localparam int CAM_W   = BLK_W + IDX_W;
  localparam int N_RINGS = 4;

  logic [CTX_WORD_W-1:0] raw_w [N_RINGS];
  logic                  r_vld [N_RINGS];
  logic [CAM_W-1:0]      r_cam [N_RINGS];
  logic [LS_W-1:0]       r_ls  [N_RINGS];

  assign raw_w[RING_USER] = ctx_user_w;
  assign raw_w[RING_OS]   = ctx_os_w;
  assign raw_w[RING_POOL] = ctx_pool_w;
  assign raw_w[RING_PHYS] = ctx_phys_w;

  for (genvar g = 0; g < N_RINGS; g++) begin : g_dec
    ctx_word_decode #(.CAM_W(CAM_W), .LS_W(LS_W)) u_dec (
      .raw_w (raw_w[g]),
      .vld   (r_vld[g]),
      .cam   (r_cam[g]),
      .ls    (r_ls[g])
    );
  end

  logic [CAM_W-1:0] tgt_cam;
  logic [CAM_W-1:0] hw_line;
  assign tgt_cam = {tgt_blk, tgt_idx};

  ctx_hw_line #(.BLK_W(BLK_W), .IDX_W(IDX_W), .PIR_W(PIR_W)) u_hw (
    .chip_blk  (chip_blk),
    .pir       (pir),
    .tid8_mode (tid8_mode),
    .line      (hw_line)
  );

  // Per-ring hit events, named for the checks below.
  logic hit_phys, hit_pool, hit_os, hit_user;
  assign hit_phys = r_vld[RING_PHYS] && (hw_line == tgt_cam);
  assign hit_pool = r_vld[RING_POOL] && (r_cam[RING_POOL] == tgt_cam);
  assign hit_os   = r_vld[RING_OS]   && (r_cam[RING_OS] == tgt_cam);
  assign hit_user = hit_os && r_vld[RING_USER] && (r_ls[RING_USER] == tgt_ls);

  logic  sel_match;
  ring_e sel_ring;

  ctx_ring_select u_sel (
    .fmt       (tgt_fmt),
    .ignore_lo (tgt_ignore),
    .hit_phys  (hit_phys),
    .hit_pool  (hit_pool),
    .hit_os    (hit_os),
    .hit_user  (hit_user),
    .sel_match (sel_match),
    .sel_ring  (sel_ring)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done  <= 1'b0;
      match <= 1'b0;
      ring  <= 2'd0;
    end else begin
      done <= start;
      if (start) begin
        match <= sel_match;
        ring  <= sel_ring;
      end
    end
  end

  // R2: strobe follows the request by one cycle, and only then
  a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  // R3: results frozen between requests
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(match) && $stable(ring)));
  // R5: wildcard format-0 target never matches
  a_r5_wildcard: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !tgt_fmt && tgt_ignore) |=> !match);
  // R7: a physical hit outranks every other ring
  a_r7_phys_first: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !tgt_fmt && !tgt_ignore && hit_phys) |=> (match && ring == 2'd3));
  // R9: user path requires a valid OS context
  a_r9_needs_os: assert property (@(posedge clk) disable iff (!rst_n)
    (start && tgt_fmt && !r_vld[RING_OS]) |=> !match);
  // R10: format 1 reports only the user code
  a_r10_user_code: assert property (@(posedge clk) disable iff (!rst_n)
    (start && tgt_fmt) |=> (!match || ring == 2'd0));
endmodule

// File: tb/ctx_cam_match_test.sv
`timescale 1ns/1ps
module ctx_cam_match_test;
  localparam int BLK_W = 4;
  localparam int IDX_W = 20;
  localparam int PIR_W = 8;
  localparam int LS_W  = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic tgt_fmt = 1'b0, tgt_ignore = 1'b0, tid8_mode = 1'b0;
  logic [BLK_W-1:0] tgt_blk = '0, chip_blk = '0;
  logic [IDX_W-1:0] tgt_idx = '0;
  logic [LS_W-1:0]  tgt_ls = '0;
  logic [31:0] ctx_user_w = '0, ctx_os_w = '0, ctx_pool_w = '0, ctx_phys_w = '0;
  logic [PIR_W-1:0] pir = '0;
  logic done, match;
  logic [1:0] ring;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ctx_cam_match uut (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_fmt(tgt_fmt),
    .tgt_blk(tgt_blk), .tgt_idx(tgt_idx), .tgt_ignore(tgt_ignore),
    .tgt_ls(tgt_ls), .ctx_user_w(ctx_user_w), .ctx_os_w(ctx_os_w),
    .ctx_pool_w(ctx_pool_w), .ctx_phys_w(ctx_phys_w), .chip_blk(chip_blk),
    .pir(pir), .tid8_mode(tid8_mode), .done(done), .match(match), .ring(ring)
  );

  // Host-order fields of the current request
  bit        u_v, o_v, p_v, h_v;
  bit [23:0] u_ls, o_cam, p_cam;

  function automatic logic [31:0] swap_bytes(input logic [31:0] h);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = h[8*(3-b) +: 8];
    return r;
  endfunction

  function automatic logic [31:0] pack(input bit v, input logic [23:0] f);
    return swap_bytes({v, 7'd0, f});
  endfunction

  function automatic logic [23:0] phys_line(input logic [3:0] cb, input logic [7:0] p, input bit t8);
    int unsigned w;
    int unsigned lo;
    w  = t8 ? 8 : 7;
    lo = (1 << w) + (int'(p) % (1 << w));
    return {cb, 20'(lo)};
  endfunction

  // returns {match, ring}
  function automatic logic [2:0] model();
    logic [23:0] tgt;
    tgt = {tgt_blk, tgt_idx};
    if (tgt_fmt) begin
      if (o_v && o_cam == tgt && u_v && u_ls == tgt_ls) return 3'b100;
      return 3'b000;
    end
    if (tgt_ignore) return 3'b000;
    if (h_v && phys_line(chip_blk, pir, tid8_mode) == tgt) return 3'b111;
    if (p_v && p_cam == tgt) return 3'b110;
    if (o_v && o_cam == tgt) return 3'b101;
    return 3'b000;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply_words();
    ctx_user_w = pack(u_v, u_ls);
    ctx_os_w   = pack(o_v, o_cam);
    ctx_pool_w = pack(p_v, p_cam);
    ctx_phys_w = pack(h_v, 24'h0);
  endtask

  task automatic issue(input string tag);
    logic [2:0] e;
    logic [2:0] held;
    @(negedge clk);
    apply_words();
    start = 1'b1;
    e = model();
    @(negedge clk);
    start = 1'b0;
    check({tag, " R2 done"}, {31'd0, done}, 32'd1);
    check({tag, " R10 result"}, {29'd0, match, ring}, {29'd0, e});
    held = {match, ring};
    // scramble inputs: outputs must not follow
    tgt_fmt = ~tgt_fmt; tgt_idx = ~tgt_idx; ctx_os_w = ~ctx_os_w;
    @(negedge clk);
    check({tag, " R2 single pulse"}, {31'd0, done}, 32'd0);
    check({tag, " R3 hold"}, {29'd0, match, ring}, {29'd0, held});
    tgt_fmt = ~tgt_fmt; tgt_idx = ~tgt_idx;
  endtask

  task automatic clear_ctx();
    u_v = 0; o_v = 0; p_v = 0; h_v = 0;
    u_ls = '0; o_cam = '0; p_cam = '0;
    tgt_fmt = 0; tgt_ignore = 0; tgt_ls = '0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [23:0] hl;
    void'($urandom(32'h1C0DE5));
    clear_ctx();
    apply_words();
    repeat (3) @(negedge clk);
    check("R1 done in reset", {31'd0, done}, 32'd0);
    check("R1 result in reset", {29'd0, match, ring}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", {30'd0, done, match}, 32'd0);

    // R6: seven-bit thread id, physical match
    chip_blk = 4'h5; pir = 8'hD3; tid8_mode = 0;
    hl = phys_line(chip_blk, pir, 0);
    {tgt_blk, tgt_idx} = hl; h_v = 1;
    issue("R6 tid7 phys");
    // R6: eight-bit width changes the line, the old target misses
    tid8_mode = 1;
    issue("R6 tid8 miss");
    {tgt_blk, tgt_idx} = phys_line(chip_blk, pir, 1);
    issue("R6 tid8 phys");
    // R7: all three rings hold the target, physical wins
    p_v = 1; p_cam = {tgt_blk, tgt_idx}; o_v = 1; o_cam = {tgt_blk, tgt_idx};
    issue("R7 three hits");
    h_v = 0;
    issue("R7 pool over os");
    p_v = 0;
    issue("R7 os last");
    // R8: valid bit clear blocks an equal CAM
    o_v = 0;
    issue("R8 os invalid");
    // R5: wildcard never matches
    o_v = 1; tgt_ignore = 1;
    issue("R5 wildcard");
    tgt_ignore = 0;
    // R4: word given in host order is misread, valid lands in bit 7
    @(negedge clk);
    ctx_os_w = {1'b1, 7'd0, o_cam}; p_v = 0; h_v = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R4 unswapped word", {29'd0, match, ring}, 32'd0);
    // R9: format 1 with every condition, then each one removed
    tgt_fmt = 1; u_v = 1; u_ls = 24'hABCDE; tgt_ls = 24'hABCDE; o_v = 1;
    issue("R9 user all");
    u_v = 0;        issue("R9 user invalid");
    u_v = 1; o_v = 0; issue("R9 os invalid");
    o_v = 1; tgt_ls = 24'hABCDF; issue("R9 ls differ");
    tgt_ls = 24'hABCDE; o_cam = o_cam ^ 24'h1; issue("R9 cam differ");

    // Random with bias toward shared target values
    for (int n = 0; n < 400; n++) begin
      logic [23:0] t;
      clear_ctx();
      chip_blk = 4'($urandom); pir = 8'($urandom); tid8_mode = 1'($urandom);
      tgt_fmt = ($urandom % 4) == 0;
      tgt_ignore = ($urandom % 6) == 0;
      t = ($urandom % 3 == 0) ? phys_line(chip_blk, pir, tid8_mode) : 24'($urandom);
      {tgt_blk, tgt_idx} = t;
      h_v = 1'($urandom); p_v = 1'($urandom); o_v = 1'($urandom); u_v = 1'($urandom);
      p_cam = ($urandom % 2) ? t : 24'($urandom);
      o_cam = ($urandom % 2) ? t : 24'($urandom);
      tgt_ls = 24'($urandom % 8);
      u_ls = 24'($urandom % 8);
      issue("R7 R9 random");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule